// File: doc/BRIEF.md
# Gain Loop Update Sync Controller

This block decides the clock cycle in which a gain-control loop takes its next averaged and decimated update sample. It drives a one-cycle start-of-decimation pulse and, when configured, a matching accumulator-reset pulse to the decimating filter in front of the loop. The filter itself is outside the block.

An update can start in two ways. The first is an external sync pin. The pin is brought into the clock domain by a two-flop synchronizer, and its rising edge is detected there. That edge loads a programmable hold-off counter, and the update starts once the delay has run out. The second is a software trigger: a self-clearing sync-now bit in the control register. It starts an update on the next edge and does not use the counter. A first-sync-only mode admits a single pin sync and then locks out further pin syncs until software re-arms it.

Software uses a single write port with two registers. Select 0 is the hold-off count, taken from write-data bits [15:0]. Select 1 is the control word. In the control word, bit 1 is first-sync-only, bit 2 is init-on-sync, and bit 3 is sync-now.

Top module: `update_sync_ctrl`

## Requirements
- R1: While rst_n is low, and after it is released, both outputs are low, the hold-off count and the control bits read as 0, the lockout is open and no countdown is running.
- R2: If sync_pin first reads high before clock edge k, its rising edge loads the counter at edge k+2. A pin that is held high gives only one trigger. The pin must go low and high again before it can trigger again.
- R3: With a hold-off count N of 1 or more, a trigger loaded at edge k+2 makes dec_start high for exactly one cycle, starting after edge k+2+N. A count of 1 gives the shortest delay.
- R4: With a hold-off count of 0, pin syncs are ignored. Writing 0 to the hold-off register while a countdown runs cancels that countdown, and no pulse follows.
- R5: A pin trigger that arrives while a countdown runs reloads the counter with the current count and restarts the delay. The earlier pending pulse is dropped.
- R6: A control write (select 1) with bit 3 set makes dec_start high for the cycle after that write edge. The hold-off count has no effect on this, including a count of 0. The bit is not stored, and each such write gives its own pulse, including back-to-back writes.
- R7: While control bit 1 (first-sync-only) is set, the first accepted pin sync closes a lockout, and later pin syncs are ignored. Sync-now still works while the lockout is closed.
- R8: The lockout reopens when fso_clr is pulsed, which also clears bit 1, or when a control write has bit 1 at 0. The next pin sync is then accepted.
- R9: acc_reset is high exactly when dec_start is high and init-on-sync (control bit 2) is set. For a sync-now write, the bit-2 value in that same write applies.
- R10: A hold-off write of a nonzero value during a countdown does not change the running delay. The new value is used from the next trigger on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_pin | input | 1 | External sync request, asynchronous to clk |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the hold-off count, 1 selects the control word |
| wr_data | input | DATA_W (16) | Write data |
| fso_clr | input | 1 | Clears first-sync-only and reopens the lockout |
| dec_start | output | 1 | One-cycle start-of-decimation pulse |
| acc_reset | output | 1 | One-cycle filter accumulator reset pulse |

## Verification
The bench targets several corner cases. The first is a count of 1, the shortest delay, where a decrement that is off by one would add or remove a cycle. The second is a pin held high for a long time, where a level-sensitive trigger would fire more than once. The third is a retrigger during a countdown, where a design that kept the old deadline would emit an extra pulse or emit it at the wrong time. The bench also writes zero during a countdown, and writes a new nonzero count during one, which checks whether the running delay is cancelled or left alone as intended. Finally, it closes the lockout and then reopens it both ways, using fso_clr and using a control write, and it checks that sync-now still gets through while the lockout is closed.

// File: rtl/usc_pkg.sv
package usc_pkg;
   localparam int CTRL_FSO_BIT = 1;
   localparam int CTRL_IOS_BIT = 2;
   localparam int CTRL_NOW_BIT = 3;
   localparam int CTRL_MIN_W   = CTRL_NOW_BIT + 1;
   localparam logic SEL_HOLD   = 1'b0;
   localparam logic SEL_CTRL   = 1'b1;

   typedef struct packed {
      logic first_only;
      logic init_on;
   } ctrl_t;
endpackage

// File: rtl/usc_pin_sync.sv
module usc_pin_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic rise_o
);
   localparam int TAPS = STAGES + 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("usc_pin_sync: STAGES must be at least 2");
   end

   logic [TAPS-1:0] chain;

   for (genvar g = 0; g < TAPS; g++) begin : g_tap
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= 1'b0;
            else        chain[0] <= pin_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[g] <= 1'b0;
            else        chain[g] <= chain[g-1];
         end
      end
   end

   assign rise_o = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/usc_regs.sv
module usc_regs
   import usc_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              lock_clr_i,
   output logic [CNT_W-1:0]  hold_o,
   output logic              hold_zero_o,
   output ctrl_t             ctrl_o,
   output ctrl_t             ctrl_next_o,
   output logic              now_o,
   output logic              abort_o,
   output logic              rearm_o
);
   if (DATA_W < CNT_W || DATA_W < CTRL_MIN_W) begin : g_bad_width
      $error("usc_regs: DATA_W too narrow for count or control word");
   end

   logic hold_wr;
   logic ctrl_wr;
   logic [CNT_W-1:0] hold_q;
   ctrl_t ctrl_q;
   ctrl_t ctrl_d;

   assign hold_wr = wr_en & (wr_sel == SEL_HOLD);
   assign ctrl_wr = wr_en & (wr_sel == SEL_CTRL);

   always_comb begin
      ctrl_d = ctrl_q;
      if (ctrl_wr) begin
         ctrl_d.first_only = wr_data[CTRL_FSO_BIT];
         ctrl_d.init_on    = wr_data[CTRL_IOS_BIT];
      end
      if (lock_clr_i) ctrl_d.first_only = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= '0;
         ctrl_q <= '0;
      end else begin
         ctrl_q <= ctrl_d;
         if (hold_wr) hold_q <= wr_data[CNT_W-1:0];
      end
   end

   assign hold_o      = hold_q;
   assign hold_zero_o = (hold_q == '0);
   assign ctrl_o      = ctrl_q;
   assign ctrl_next_o = ctrl_d;
   assign now_o       = ctrl_wr & wr_data[CTRL_NOW_BIT];
   assign abort_o     = hold_wr & (wr_data[CNT_W-1:0] == '0);
   assign rearm_o     = lock_clr_i | (ctrl_wr & ~wr_data[CTRL_FSO_BIT]);
endmodule

// File: rtl/usc_gate.sv
module usc_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic rise_i,
   input  logic hold_zero_i,
   input  logic first_only_i,
   input  logic rearm_i,
   output logic trig_o,
   output logic locked_o
);
   logic locked_q;

   assign trig_o = rise_i & ~hold_zero_i & ~(first_only_i & locked_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     locked_q <= 1'b0;
      else if (rearm_i)               locked_q <= 1'b0;
      else if (trig_o & first_only_i) locked_q <= 1'b1;
   end

   assign locked_o = locked_q;
endmodule

// File: rtl/usc_holdoff.sv
module usc_holdoff #(
   parameter int CNT_W          = 16,
   parameter bit RETRIG_RESTART = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             trig_i,
   input  logic [CNT_W-1:0] load_i,
   input  logic             abort_i,
   output logic             fire_o,
   output logic [CNT_W-1:0] cnt_o
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   if (CNT_W < 1) begin : g_bad_cnt
      $error("usc_holdoff: CNT_W must be positive");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             take;

   if (RETRIG_RESTART) begin : g_restart
      assign take = trig_i;
   end else begin : g_ignore_busy
      assign take = trig_i & (cnt_q == '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (abort_i)        cnt_q <= '0;
      else if (take)           cnt_q <= load_i;
      else if (cnt_q != '0)    cnt_q <= cnt_q - ONE;
   end

   assign fire_o = (cnt_q == ONE) & ~abort_i & ~take;
   assign cnt_o  = cnt_q;
endmodule

// File: rtl/update_sync_ctrl.sv
module update_sync_ctrl
   import usc_pkg::*;
#(
   parameter int CNT_W          = 16,
   parameter int DATA_W         = 16,
   parameter int SYNC_STAGES    = 2,
   parameter bit RETRIG_RESTART = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sync_pin,
   input  logic              wr_en,
   input  logic              wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              fso_clr,
   output logic              dec_start,
   output logic              acc_reset
);
   logic             rise;
   logic [CNT_W-1:0] hold;
   logic             hold_zero;
   ctrl_t            ctrl_q;
   ctrl_t            ctrl_d;
   logic             now;
   logic             abort;
   logic             rearm;
   logic             trig;
   logic             locked;
   logic             fire;
   logic [CNT_W-1:0] cnt;
   logic             first_only;
   logic             start_d;

   usc_pin_sync #(.STAGES(SYNC_STAGES)) u_pin (
      .clk(clk), .rst_n(rst_n), .pin_i(sync_pin), .rise_o(rise)
   );

   usc_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .lock_clr_i(fso_clr), .hold_o(hold),
      .hold_zero_o(hold_zero), .ctrl_o(ctrl_q), .ctrl_next_o(ctrl_d),
      .now_o(now), .abort_o(abort), .rearm_o(rearm)
   );

   assign first_only = ctrl_q.first_only;

   usc_gate u_gate (
      .clk(clk), .rst_n(rst_n), .rise_i(rise), .hold_zero_i(hold_zero),
      .first_only_i(first_only), .rearm_i(rearm), .trig_o(trig),
      .locked_o(locked)
   );

   usc_holdoff #(.CNT_W(CNT_W), .RETRIG_RESTART(RETRIG_RESTART)) u_hold (
      .clk(clk), .rst_n(rst_n), .trig_i(trig), .load_i(hold),
      .abort_i(abort), .fire_o(fire), .cnt_o(cnt)
   );

   assign start_d = fire | now;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dec_start <= 1'b0;
         acc_reset <= 1'b0;
      end else begin
         dec_start <= start_d;
         acc_reset <= start_d & ctrl_d.init_on;
      end
   end
endmodule

module usc_checker #(
   parameter int CNT_W  = 16,
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              wr_sel,
   input logic [DATA_W-1:0] wr_data,
   input logic              dec_start,
   input logic              acc_reset,
   input logic              trig,
   input logic              abort,
   input logic [CNT_W-1:0]  cnt,
   input logic [CNT_W-1:0]  hold,
   input logic              locked,
   input logic              first_only
);
   assert_now_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel && wr_data[3]) |=> dec_start);

   assert_acc_needs_dec_R9: assert property (@(posedge clk) disable iff (!rst_n)
      acc_reset |-> dec_start);

   assert_zero_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (hold == '0) |-> !trig);

   assert_lockout_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (first_only && locked) |-> !trig);

   assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (trig && !abort && cnt == '0) |=> (cnt == $past(hold)));

   assert_expiry_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == CNT_W'(1) && !trig && !abort) |=> dec_start);
endmodule

bind update_sync_ctrl usc_checker #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
   .wr_data(wr_data), .dec_start(dec_start), .acc_reset(acc_reset),
   .trig(trig), .abort(abort), .cnt(cnt), .hold(hold), .locked(locked),
   .first_only(first_only)
);

// File: tb/tb_update_sync_ctrl.sv
module tb_update_sync_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int S = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sync_pin = 1'b0;
   logic        wr_en = 1'b0;
   logic        wr_sel = 1'b0;
   logic [15:0] wr_data = '0;
   logic        fso_clr = 1'b0;
   logic        dec_start;
   logic        acc_reset;

   int checks = 0;
   int fails = 0;
   bit comparing = 1'b0;
   bit done = 1'b0;
   string cur_req = "R1";

   always #(CLK_PERIOD/2) clk = ~clk;

   update_sync_ctrl dut (
      .clk(clk), .rst_n(rst_n), .sync_pin(sync_pin), .wr_en(wr_en),
      .wr_sel(wr_sel), .wr_data(wr_data), .fso_clr(fso_clr),
      .dec_start(dec_start), .acc_reset(acc_reset)
   );

   // behavioural reference
   bit hist [0:S];
   int m_hold = 0, m_cnt = 0;
   bit m_fso = 0, m_ios = 0, m_lock = 0, m_dec = 0, m_acc = 0;
   int pulses = 0;

   always @(posedge clk) begin
      bit rise, cw, hw, now, abort_w, trig, fire, rearm;
      if (!rst_n) begin
         for (int j = 0; j <= S; j++) hist[j] = 1'b0;
         m_hold = 0; m_cnt = 0; m_fso = 0; m_ios = 0; m_lock = 0;
         m_dec = 0; m_acc = 0;
      end else begin
         rise    = hist[S-1] && !hist[S];
         cw      = wr_en && wr_sel;
         hw      = wr_en && !wr_sel;
         now     = cw && wr_data[3];
         abort_w = hw && (wr_data == 16'd0);
         trig    = rise && (m_hold != 0) && !(m_fso && m_lock);
         fire    = 1'b0;
         if (abort_w) m_cnt = 0;
         else if (trig) m_cnt = m_hold;
         else if (m_cnt != 0) begin
            if (m_cnt == 1) fire = 1'b1;
            m_cnt = m_cnt - 1;
         end
         rearm = fso_clr || (cw && !wr_data[1]);
         if (rearm) m_lock = 1'b0;
         else if (trig && m_fso) m_lock = 1'b1;
         if (cw) begin m_fso = wr_data[1]; m_ios = wr_data[2]; end
         if (fso_clr) m_fso = 1'b0;
         if (hw) m_hold = int'(wr_data);
         m_dec = fire || now;
         m_acc = m_dec && m_ios;
         if (m_dec) pulses++;
         for (int j = S; j > 0; j--) hist[j] = hist[j-1];
         hist[0] = sync_pin;
      end
   end

   always @(negedge clk) begin
      if (comparing && !done) begin
         checks++;
         if (dec_start !== m_dec) begin
            fails++;
            $display("FAIL %s dec_start actual=%0b expected=%0b t=%0t", cur_req, dec_start, m_dec, $time);
         end
         checks++;
         if (acc_reset !== m_acc) begin
            fails++;
            $display("FAIL %s acc_reset actual=%0b expected=%0b t=%0t", cur_req, acc_reset, m_acc, $time);
         end
      end
   end

   task automatic wr(input logic sel, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic pin(input int len);
      @(negedge clk);
      sync_pin = 1'b1;
      repeat (len) @(negedge clk);
      sync_pin = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic expect_pulses(input string req, input int exp_n, input int got);
      checks++;
      if (got != exp_n) begin
         fails++;
         $display("FAIL %s pulse count actual=%0d expected=%0d", req, got, exp_n);
      end
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         finish_run();
      end
   end

   initial begin
      int p0;
      repeat (3) @(negedge clk);
      // R1: outputs quiet during reset
      checks++;
      if (dec_start !== 1'b0 || acc_reset !== 1'b0) begin
         fails++;
         $display("FAIL R1 reset outputs actual=%0b%0b expected=00", dec_start, acc_reset);
      end
      comparing = 1'b1;
      rst_n = 1'b1;
      idle(3);

      cur_req = "R4 zero count"; p0 = pulses;
      pin(2); idle(10);
      expect_pulses("R4", 0, pulses - p0);

      cur_req = "R3 minimum delay"; wr(1'b0, 16'd1); p0 = pulses;
      pin(1); idle(8);
      expect_pulses("R3", 1, pulses - p0);

      cur_req = "R2 held pin"; wr(1'b0, 16'd5); p0 = pulses;
      pin(30); idle(12);
      expect_pulses("R2", 1, pulses - p0);

      cur_req = "R4 abort"; wr(1'b0, 16'd20); p0 = pulses;
      pin(1); idle(5); wr(1'b0, 16'd0); idle(30);
      expect_pulses("R4", 0, pulses - p0);

      cur_req = "R10 rewrite"; wr(1'b0, 16'd12); p0 = pulses;
      pin(1); idle(3); wr(1'b0, 16'd3); idle(20);
      expect_pulses("R10", 1, pulses - p0);

      cur_req = "R5 retrigger"; wr(1'b0, 16'd8); p0 = pulses;
      pin(1); idle(4); pin(1); idle(20);
      expect_pulses("R5", 1, pulses - p0);

      cur_req = "R6 sync now"; wr(1'b0, 16'd0); p0 = pulses;
      wr(1'b1, 16'h0008);
      @(negedge clk); wr_en = 1'b1; wr_sel = 1'b1; wr_data = 16'h0008;
      @(negedge clk); @(negedge clk); wr_en = 1'b0; wr_data = '0;
      idle(4);
      expect_pulses("R6", 3, pulses - p0);

      cur_req = "R7 lockout"; wr(1'b0, 16'd2); wr(1'b1, 16'h0002); p0 = pulses;
      pin(1); idle(6); pin(1); idle(6); pin(3); idle(6);
      expect_pulses("R7", 1, pulses - p0);
      wr(1'b1, 16'h000A); idle(3);
      expect_pulses("R7", 2, pulses - p0);

      cur_req = "R8 rearm"; p0 = pulses;
      @(negedge clk); fso_clr = 1'b1; @(negedge clk); fso_clr = 1'b0;
      pin(1); idle(6);
      wr(1'b1, 16'h0002); pin(1); idle(6); pin(1); idle(6);
      wr(1'b1, 16'h0000); pin(1); idle(6);
      expect_pulses("R8", 3, pulses - p0);

      cur_req = "R9 init on sync"; wr(1'b1, 16'h0004); p0 = pulses;
      pin(1); idle(6);
      wr(1'b1, 16'h0008); idle(2);
      wr(1'b1, 16'h000C); idle(2);
      wr(1'b0, 16'd7); pin(2); idle(12);
      expect_pulses("R9", 4, pulses - p0);

      idle(4);
      finish_run();
   end
endmodule